// File: doc/BRIEF.md
# Fetch and Exception Control Sequencer

This block is the control core of a small 16-bit processor. It owns the program counter, the status register and a one-word prefetch register, plus four shadow registers that an exception handler uses: the saved PC, the saved status, the user-register shadow and the exception number. A three-state machine steps between loading an instruction word, executing from the prefetch register, and vectoring into a handler. Every memory access it makes is a single-cycle word read on a combinational read port.

The execute stage sees the current instruction on `ir_word` while `ir_valid` is high. In that same cycle it reports what the instruction does to control state: an exception request with its code, a return from exception, a write to the PC, a status write, or a write to a shadow register. A return from exception restores the PC and the status from their shadows. The execute stage loads the named register from `eur_out`.

States: `ST_FETCH` (need-fetch), `ST_EXEC` (normal execute) and `ST_VECTOR` (exception start). The transitions are:
- `ST_FETCH` to `ST_EXEC` on an aligned fetch.
- `ST_FETCH` to `ST_VECTOR` on an odd PC.
- `ST_EXEC` to `ST_EXEC` on sequential flow.
- `ST_EXEC` to `ST_FETCH` on a PC write or a return from exception.
- `ST_EXEC` to `ST_VECTOR` on an interrupt or an exception request.
- `ST_VECTOR` to `ST_FETCH` always.

Exception codes:
- 0: interrupt line 0
- 1: interrupt line 1
- 2: misaligned word access
- 3: illegal instruction

Top module: `fetch_exc_seq`

## Requirements
- R1: After reset the machine is in need-fetch, the PC equals `RESET_PC`, the status is 0 and `ir_valid` is low.
- R2: In need-fetch with an even PC, the block reads the word at the PC into the prefetch register, adds 2 to the PC and enters execute at the next edge.
- R3: In execute, an instruction that does not redirect flow loads the word at the PC into the prefetch register and adds 2 to the PC.
- R4: An instruction that writes the PC loads `ex_pc_val` into the PC and returns to need-fetch. The prefetched word is dropped, and the next instruction comes from the new PC.
- R5: An exception request with `ir_valid` high stores the PC minus 2 (the current instruction's address) as the saved PC and stores `ex_exc_code` as the exception number. The machine then enters exception start.
- R6: In exception start, the block reads the word at `VEC_BASE + 2*code` into the PC. The old status goes to the saved status, status bits 1:0 (the interrupt enables) are cleared, and need-fetch follows.
- R7: In execute, interrupt line i is taken only when `irq[i]` and status bit i are both set. Line 0 wins over line 1. `ir_valid` stays low, the saved PC is PC minus 2 and the code is i. A line whose enable bit is clear is ignored.
- R8: In need-fetch with an odd PC, no read is issued. The saved PC is the odd PC and the code is 2.
- R9: A return from exception loads the PC from the saved PC and the status from the saved status, then goes to need-fetch. `eur_out` holds the user-register shadow.
- R10: A shadow write with `ir_valid` high writes `sh_wdata` to the register that `sh_sel` selects: 0 saved PC, 1 saved status, 2 user shadow, 3 exception number.
- R11: A status write (`ex_sr_wr`) is applied on an instruction that raises no exception and does not return.
- R12: Execute-stage inputs have no effect when `ir_valid` is low. This covers need-fetch, exception start, and a cycle in which an interrupt is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_req | output | 1 | Word read strobe |
| mem_addr | output | 16 | Read address |
| mem_rdata | input | 16 | Read data, valid in the same cycle |
| ir_valid | output | 1 | Instruction on `ir_word` executes this cycle |
| ir_word | output | 16 | Prefetch register |
| irq | input | 2 | Interrupt request lines |
| ex_exc | input | 1 | Exception request from execute or memory |
| ex_exc_code | input | 16 | Code of that request (trap register or immediate) |
| ex_reti | input | 1 | Return from exception |
| ex_pc_wr | input | 1 | Instruction writes the PC |
| ex_pc_val | input | 16 | New PC value |
| ex_sr_wr | input | 1 | Instruction writes the status |
| ex_sr_val | input | 16 | New status value |
| sh_wr | input | 1 | Shadow register write |
| sh_sel | input | 2 | Shadow register select |
| sh_wdata | input | 16 | Shadow write data |
| pc_out | output | 16 | Program counter |
| sr_out | output | 16 | Status register |
| epc_out | output | 16 | Saved PC |
| esr_out | output | 16 | Saved status |
| eur_out | output | 16 | User-register shadow |
| exc_num_out | output | 16 | Exception number |

## Verification
Some properties can be checked every cycle, and the assertions cover those:
- Every read address is even.
- An enabled, pending interrupt always blocks `ir_valid`.
- A fetch always advances the PC by 2 and captures the read word.
- Exception start always clears both enables and moves to need-fetch.
- A PC write and a return each land the right PC.

Only the bench scenarios can show the full vector flow. They cover the handler addresses for each code, the line priority, the saved status values across nested sequences, the odd-PC fault, and that execute inputs in dead cycles change nothing.

// File: rtl/seq_pkg.sv
package seq_pkg;
    localparam int WORD_W    = 16;
    localparam int IRQ_LINES = 2;
    localparam int SH_SEL_W  = 2;

    localparam logic [WORD_W-1:0] CODE_MISALIGN = 16'd2;
    localparam logic [WORD_W-1:0] CODE_ILLEGAL  = 16'd3;

    typedef enum logic [1:0] {
        ST_FETCH  = 2'd0,
        ST_EXEC   = 2'd1,
        ST_VECTOR = 2'd2
    } seq_state_e;

    typedef enum logic [SH_SEL_W-1:0] {
        SH_EPC = 2'd0,
        SH_ESR = 2'd1,
        SH_EUR = 2'd2,
        SH_NUM = 2'd3
    } sh_sel_e;
endpackage

// File: rtl/seq_irq_pick.sv
module seq_irq_pick #(
    parameter int LINES  = 2,
    parameter int CODE_W = 16
) (
    input  logic [LINES-1:0]  pend,
    input  logic [LINES-1:0]  enable,
    output logic              take,
    output logic [CODE_W-1:0] code
);
    logic [LINES-1:0] live;

    genvar g;
    generate
        for (g = 0; g < LINES; g++) begin : g_mask
            assign live[g] = pend[g] & enable[g];
        end
    endgenerate

    // lowest line index wins
    always_comb begin
        take = 1'b0;
        code = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (live[i]) begin
                take = 1'b1;
                code = CODE_W'(i);
            end
        end
    end
endmodule

// File: rtl/seq_shadow_bank.sv
module seq_shadow_bank
    import seq_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cap_en,
    input  logic [W-1:0]        cap_pc,
    input  logic [W-1:0]        cap_code,
    input  logic                sr_cap_en,
    input  logic [W-1:0]        sr_in,
    input  logic                wr_en,
    input  logic [SH_SEL_W-1:0] wr_sel,
    input  logic [W-1:0]        wr_data,
    output logic [W-1:0]        epc,
    output logic [W-1:0]        esr,
    output logic [W-1:0]        eur,
    output logic [W-1:0]        num
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            epc <= '0;
            esr <= '0;
            eur <= '0;
            num <= '0;
        end else begin
            if (cap_en) begin
                epc <= cap_pc;
                num <= cap_code;
            end else if (wr_en) begin
                unique case (sh_sel_e'(wr_sel))
                    SH_EPC: epc <= wr_data;
                    SH_ESR: esr <= wr_data;
                    SH_EUR: eur <= wr_data;
                    SH_NUM: num <= wr_data;
                    default: ;
                endcase
            end
            if (sr_cap_en) esr <= sr_in;
        end
    end
endmodule

// File: rtl/fetch_exc_seq.sv
module fetch_exc_seq
    import seq_pkg::*;
#(
    parameter logic [15:0] RESET_PC = 16'h0040,
    parameter logic [15:0] VEC_BASE = 16'h0100
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic        mem_req,
    output logic [15:0] mem_addr,
    input  logic [15:0] mem_rdata,
    output logic        ir_valid,
    output logic [15:0] ir_word,
    input  logic [1:0]  irq,
    input  logic        ex_exc,
    input  logic [15:0] ex_exc_code,
    input  logic        ex_reti,
    input  logic        ex_pc_wr,
    input  logic [15:0] ex_pc_val,
    input  logic        ex_sr_wr,
    input  logic [15:0] ex_sr_val,
    input  logic        sh_wr,
    input  logic [1:0]  sh_sel,
    input  logic [15:0] sh_wdata,
    output logic [15:0] pc_out,
    output logic [15:0] sr_out,
    output logic [15:0] epc_out,
    output logic [15:0] esr_out,
    output logic [15:0] eur_out,
    output logic [15:0] exc_num_out
);
    localparam logic [WORD_W-1:0] STEP = WORD_W'(2);

    seq_state_e         state_q, state_d;
    logic [WORD_W-1:0]  pc_q, pc_d, sr_q, sr_d, pf_q, pf_d;
    logic               irq_take;
    logic [WORD_W-1:0]  irq_code;
    logic               cap_en;
    logic [WORD_W-1:0]  cap_pc, cap_code;
    logic               in_exec, instr_ok, sh_we, vec_phase;

    seq_irq_pick #(.LINES(IRQ_LINES), .CODE_W(WORD_W)) u_pick (
        .pend   (irq),
        .enable (sr_q[IRQ_LINES-1:0]),
        .take   (irq_take),
        .code   (irq_code)
    );

    assign in_exec   = (state_q == ST_EXEC);
    assign instr_ok  = in_exec && !irq_take;
    assign vec_phase = (state_q == ST_VECTOR);
    assign sh_we     = instr_ok && sh_wr && !ex_exc && !ex_reti;

    seq_shadow_bank #(.W(WORD_W)) u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_en    (cap_en),
        .cap_pc    (cap_pc),
        .cap_code  (cap_code),
        .sr_cap_en (vec_phase),
        .sr_in     (sr_q),
        .wr_en     (sh_we),
        .wr_sel    (sh_sel),
        .wr_data   (sh_wdata),
        .epc       (epc_out),
        .esr       (esr_out),
        .eur       (eur_out),
        .num       (exc_num_out)
    );

    // next state and register updates
    always_comb begin
        state_d  = state_q;
        pc_d     = pc_q;
        sr_d     = sr_q;
        pf_d     = pf_q;
        cap_en   = 1'b0;
        cap_pc   = pc_q - STEP;
        cap_code = '0;
        unique case (state_q)
            ST_FETCH: begin
                if (pc_q[0]) begin
                    cap_en   = 1'b1;
                    cap_pc   = pc_q;
                    cap_code = CODE_MISALIGN;
                    state_d  = ST_VECTOR;
                end else begin
                    pf_d    = mem_rdata;
                    pc_d    = pc_q + STEP;
                    state_d = ST_EXEC;
                end
            end
            ST_EXEC: begin
                if (irq_take) begin
                    cap_en   = 1'b1;
                    cap_code = irq_code;
                    state_d  = ST_VECTOR;
                end else if (ex_exc) begin
                    cap_en   = 1'b1;
                    cap_code = ex_exc_code;
                    state_d  = ST_VECTOR;
                end else if (ex_reti) begin
                    pc_d    = epc_out;
                    sr_d    = esr_out;
                    state_d = ST_FETCH;
                end else begin
                    if (ex_sr_wr) sr_d = ex_sr_val;
                    if (ex_pc_wr) begin
                        pc_d    = ex_pc_val;
                        state_d = ST_FETCH;
                    end else begin
                        pf_d = mem_rdata;
                        pc_d = pc_q + STEP;
                    end
                end
            end
            ST_VECTOR: begin
                pc_d = mem_rdata;
                sr_d = sr_q & ~WORD_W'((1 << IRQ_LINES) - 1);
                state_d = ST_FETCH;
            end
            default: state_d = ST_FETCH;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FETCH;
        else        state_q <= state_d;
    end

    // architectural registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= RESET_PC;
            sr_q <= '0;
            pf_q <= '0;
        end else begin
            pc_q <= pc_d;
            sr_q <= sr_d;
            pf_q <= pf_d;
        end
    end

    // outputs
    always_comb begin
        mem_req  = 1'b0;
        mem_addr = pc_q;
        unique case (state_q)
            ST_FETCH:  mem_req = !pc_q[0];
            ST_EXEC:   mem_req = instr_ok;
            ST_VECTOR: begin
                mem_req  = 1'b1;
                mem_addr = VEC_BASE + {exc_num_out[WORD_W-2:0], 1'b0};
            end
            default: mem_req = 1'b0;
        endcase
        ir_valid = instr_ok;
        ir_word  = pf_q;
        pc_out   = pc_q;
        sr_out   = sr_q;
    end
endmodule

// File: rtl/fetch_exc_seq_chk.sv
module fetch_exc_seq_chk
    import seq_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input seq_state_e  state,
    input logic        mem_req,
    input logic [15:0] mem_addr,
    input logic [15:0] mem_rdata,
    input logic        ir_valid,
    input logic [15:0] ir_word,
    input logic [1:0]  irq,
    input logic        ex_exc,
    input logic        ex_reti,
    input logic        ex_pc_wr,
    input logic [15:0] ex_pc_val,
    input logic [15:0] pc_out,
    input logic [15:0] sr_out,
    input logic [15:0] epc_out,
    input logic [15:0] esr_out
);
    // R6
    even_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !mem_addr[0]);

    // R2
    fetch_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH && !pc_out[0]) |=>
        (state == ST_EXEC && pc_out == $past(pc_out) + 16'd2 && ir_word == $past(mem_rdata)));

    // R7
    irq_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && |(irq & sr_out[1:0])) |-> !ir_valid);

    // R6
    vector_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_VECTOR) |=> (state == ST_FETCH && sr_out[1:0] == 2'b00));

    // R5
    exc_epc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ir_valid && ex_exc) |=> (state == ST_VECTOR && epc_out == $past(pc_out) - 16'd2));

    // R4
    pc_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ir_valid && ex_pc_wr && !ex_exc && !ex_reti) |=>
        (state == ST_FETCH && pc_out == $past(ex_pc_val)));

    // R9
    reti_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ir_valid && ex_reti && !ex_exc) |=>
        (pc_out == $past(epc_out) && sr_out == $past(esr_out)));
endmodule

bind fetch_exc_seq fetch_exc_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state_q),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata),
    .ir_valid  (ir_valid),
    .ir_word   (ir_word),
    .irq       (irq),
    .ex_exc    (ex_exc),
    .ex_reti   (ex_reti),
    .ex_pc_wr  (ex_pc_wr),
    .ex_pc_val (ex_pc_val),
    .pc_out    (pc_out),
    .sr_out    (sr_out),
    .epc_out   (epc_out),
    .esr_out   (esr_out)
);

// File: tb/test_fetch_exc_seq.sv
module test_fetch_exc_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_req, ir_valid;
    logic [15:0] mem_addr, mem_rdata, ir_word;
    logic [1:0]  irq = '0;
    logic        ex_exc = 0, ex_reti = 0, ex_pc_wr = 0, ex_sr_wr = 0, sh_wr = 0;
    logic [15:0] ex_exc_code = '0, ex_pc_val = '0, ex_sr_val = '0, sh_wdata = '0;
    logic [1:0]  sh_sel = '0;
    logic [15:0] pc_out, sr_out, epc_out, esr_out, eur_out, exc_num_out;

    always #5 clk = ~clk;

    // memory model: vectors at 0x100.. hold 0x0400 + code*0x40, other words are addr ^ 0x5A00
    always_comb begin
        if (mem_addr >= 16'h0100 && mem_addr < 16'h0120)
            mem_rdata = 16'h0400 + ((mem_addr - 16'h0100) << 5);
        else
            mem_rdata = mem_addr ^ 16'h5A00;
    end

    fetch_exc_seq i_fetch_exc_seq (
        .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .ir_valid(ir_valid), .ir_word(ir_word), .irq(irq),
        .ex_exc(ex_exc), .ex_exc_code(ex_exc_code), .ex_reti(ex_reti),
        .ex_pc_wr(ex_pc_wr), .ex_pc_val(ex_pc_val), .ex_sr_wr(ex_sr_wr),
        .ex_sr_val(ex_sr_val), .sh_wr(sh_wr), .sh_sel(sh_sel), .sh_wdata(sh_wdata),
        .pc_out(pc_out), .sr_out(sr_out), .epc_out(epc_out), .esr_out(esr_out),
        .eur_out(eur_out), .exc_num_out(exc_num_out)
    );

    typedef enum int {F_PC, F_SR, F_IR, F_IRV, F_EPC, F_ESR, F_EUR, F_NUM, F_ADDR, F_REQ} fld_e;
    typedef struct {int cyc; fld_e fld; logic [15:0] val; string req;} item_t;

    item_t sb[$];
    int    pe = 0;
    int    compared = 0;
    int    mismatched = 0;
    bit    finished = 0;

    always @(posedge clk) pe <= pe + 1;

    function automatic logic [15:0] pick(fld_e f);
        case (f)
            F_PC:   return pc_out;
            F_SR:   return sr_out;
            F_IR:   return ir_word;
            F_IRV:  return {15'd0, ir_valid};
            F_EPC:  return epc_out;
            F_ESR:  return esr_out;
            F_EUR:  return eur_out;
            F_NUM:  return exc_num_out;
            F_ADDR: return mem_addr;
            default: return {15'd0, mem_req};
        endcase
    endfunction

    // monitor: pops due items and compares
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].cyc <= pe) begin
            item_t it;
            logic [15:0] act;
            it = sb.pop_front();
            act = pick(it.fld);
            compared++;
            if (act !== it.val) begin
                mismatched++;
                $display("FAIL %s field %s actual %h expected %h", it.req, it.fld.name(), act, it.val);
            end
        end
    end

    // driver side: dcyc 0 = this cycle, 1 = after the next edge
    task automatic exp(int dcyc, fld_e f, logic [15:0] v, string r);
        sb.push_back('{pe + dcyc, f, v, r});
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
        irq = '0; ex_exc = 0; ex_reti = 0; ex_pc_wr = 0; ex_sr_wr = 0; sh_wr = 0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        mismatched++;
        $display("FAIL watchdog actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        // R1 reset state
        exp(0, F_PC, 16'h0040, "R1"); exp(0, F_SR, 16'h0000, "R1");
        exp(0, F_IRV, 16'h0, "R1");   exp(0, F_ADDR, 16'h0040, "R2");
        // R2 first fetch
        exp(1, F_PC, 16'h0042, "R2"); exp(1, F_IR, 16'h5A40, "R2"); exp(1, F_IRV, 16'h1, "R2");
        tick();
        // R3 sequential
        exp(1, F_PC, 16'h0044, "R3"); exp(1, F_IR, 16'h5A42, "R3");
        tick();
        // R11 status write enables both lines
        ex_sr_wr = 1; ex_sr_val = 16'h0003;
        exp(1, F_SR, 16'h0003, "R11"); exp(1, F_PC, 16'h0046, "R3");
        tick();
        // R10 user shadow write
        sh_wr = 1; sh_sel = 2'd2; sh_wdata = 16'hBEEF;
        exp(1, F_EUR, 16'hBEEF, "R10"); exp(1, F_PC, 16'h0048, "R3");
        tick();
        // R7 line 1 taken; R12 simultaneous PC write ignored
        irq = 2'b10; ex_pc_wr = 1; ex_pc_val = 16'h0300;
        exp(0, F_IRV, 16'h0, "R7");
        exp(1, F_NUM, 16'h0001, "R7"); exp(1, F_EPC, 16'h0046, "R7"); exp(1, F_PC, 16'h0048, "R12");
        tick();
        // R6 vector for code 1
        exp(0, F_ADDR, 16'h0102, "R6");
        exp(1, F_PC, 16'h0440, "R6"); exp(1, F_ESR, 16'h0003, "R6"); exp(1, F_SR, 16'h0000, "R6");
        tick();
        exp(1, F_PC, 16'h0442, "R2"); exp(1, F_IR, 16'h5E40, "R2");
        tick();
        // R7 disabled lines ignored
        irq = 2'b11;
        exp(0, F_IRV, 16'h1, "R7"); exp(1, F_PC, 16'h0444, "R7");
        tick();
        ex_sr_wr = 1; ex_sr_val = 16'h0003;
        exp(1, F_SR, 16'h0003, "R11");
        tick();
        // R7 line 0 has priority
        irq = 2'b11;
        exp(1, F_NUM, 16'h0000, "R7"); exp(1, F_EPC, 16'h0444, "R7");
        tick();
        exp(0, F_ADDR, 16'h0100, "R6"); exp(1, F_PC, 16'h0400, "R6"); exp(1, F_SR, 16'h0000, "R6");
        tick();
        exp(1, F_PC, 16'h0402, "R2"); exp(1, F_IR, 16'h5E00, "R2");
        tick();
        // R5 illegal-instruction request from execute
        ex_exc = 1; ex_exc_code = 16'h0003;
        exp(1, F_NUM, 16'h0003, "R5"); exp(1, F_EPC, 16'h0400, "R5");
        tick();
        // R12 execute inputs ignored during vector phase
        ex_pc_wr = 1; ex_pc_val = 16'h0700; ex_sr_wr = 1; ex_sr_val = 16'h00FF;
        exp(0, F_ADDR, 16'h0106, "R6");
        exp(1, F_PC, 16'h04C0, "R6"); exp(1, F_ESR, 16'h0000, "R6"); exp(1, F_SR, 16'h0000, "R12");
        tick();
        exp(1, F_PC, 16'h04C2, "R2"); exp(1, F_IR, 16'h5EC0, "R2");
        tick();
        sh_wr = 1; sh_sel = 2'd1; sh_wdata = 16'h0012;
        exp(1, F_ESR, 16'h0012, "R10");
        tick();
        sh_wr = 1; sh_sel = 2'd0; sh_wdata = 16'h0500;
        exp(1, F_EPC, 16'h0500, "R10"); exp(1, F_PC, 16'h04C6, "R3");
        tick();
        // R9 return from exception
        ex_reti = 1;
        exp(1, F_PC, 16'h0500, "R9"); exp(1, F_SR, 16'h0012, "R9");
        exp(1, F_EUR, 16'hBEEF, "R9"); exp(1, F_IRV, 16'h0, "R9");
        tick();
        exp(1, F_PC, 16'h0502, "R2");
        tick();
        // R4 PC write to odd address
        ex_pc_wr = 1; ex_pc_val = 16'h0603;
        exp(1, F_PC, 16'h0603, "R4"); exp(1, F_IRV, 16'h0, "R4");
        tick();
        // R8 misaligned fetch; R12 PC write ignored in need-fetch
        ex_pc_wr = 1; ex_pc_val = 16'h0700;
        exp(0, F_REQ, 16'h0, "R8");
        exp(1, F_NUM, 16'h0002, "R8"); exp(1, F_EPC, 16'h0603, "R8"); exp(1, F_PC, 16'h0603, "R12");
        tick();
        exp(0, F_ADDR, 16'h0104, "R6");
        exp(1, F_PC, 16'h0480, "R6"); exp(1, F_ESR, 16'h0012, "R6"); exp(1, F_SR, 16'h0010, "R6");
        tick();
        exp(1, F_PC, 16'h0482, "R2");
        tick();
        // R4 prefetched word dropped, refetch at new PC
        ex_pc_wr = 1; ex_pc_val = 16'h0200;
        exp(1, F_PC, 16'h0200, "R4");
        tick();
        exp(1, F_PC, 16'h0202, "R4"); exp(1, F_IR, 16'h5800, "R4");
        tick();
        repeat (3) tick();
        if (sb.size() != 0) begin
            mismatched++;
            $display("FAIL scoreboard actual %0d left expected 0", sb.size());
        end
        finish_run();
    end
endmodule